// File: doc/BRIEF.md
# Shared ALU Reservation Station

This block lets several independent requesters share one pipelined ALU. Each requester owns a slot, and each slot runs a small controller. The controller takes one operand pair from its requester and sends it to the ALU, tagged with the slot's index. It then waits for the result that carries that index and presents the result on the slot's own output port. All three sides use valid/ready handshakes. The ALU result path has no ready signal, because a slot that is waiting for a result can always take it.

Each controller has four phases: accept, wait-to-issue, wait-for-result and wait-for-output. Two of these waits are skipped when the far side is already ready. If the ALU grants the slot in the cycle the operands arrive, they go straight through without being buffered. If the output consumer is ready in the cycle the result returns, the result passes straight to the output. When several slots compete for the ALU, the lowest-numbered slot wins.

Top module: `rs_alu_share`

## Requirements
- R1: After a synchronous reset (`rst` high), every slot is in the accept phase: `in_ready` is all ones, and `out_valid` is all zeros.
- R2: A slot holds at most one operation. `in_ready[i]` is high exactly when slot i has no accepted operation that is still waiting to be delivered.
- R3: When slot i is granted the ALU with `alu_ready` high in the cycle its input is accepted, `alu_valid` is high in that same cycle and carries the incoming `in_a`/`in_b` slice of slot i.
- R4: When an accepted operation is not issued in its accept cycle, the slot keeps the operands. It issues them unchanged in a later cycle.
- R5: `alu_valid` is high whenever any slot has an operation to issue. `alu_id` names the lowest-numbered such slot. Slots that lose keep their buffered operands unchanged.
- R6: `alu_id` carries the issuing slot's index (slot i is sent as value i). A result with `res_valid` and `res_id` equal to j is delivered only on output slot j.
- R7: In the cycle a result arrives for slot i, `out_valid[i]` is high and the slot-i slice of `out_data` equals `res_data`.
- R8: If a result is not taken in its arrival cycle, `out_valid[i]` and the slot-i slice of `out_data` stay unchanged until `out_valid[i]` and `out_ready[i]` are both high at a clock edge.
- R9: Every accepted operation produces exactly one output on its own slot. The output carries the ALU's result unchanged, so no operation is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NSLOT | Per-slot operand valid |
| in_ready | output | NSLOT | Per-slot operand ready (slot idle) |
| in_a | input | NSLOT*DW | Per-slot first operand, slot i at bits [i*DW +: DW] |
| in_b | input | NSLOT*DW | Per-slot second operand, same packing |
| alu_valid | output | 1 | Operation offered to the ALU |
| alu_ready | input | 1 | ALU accepts the offered operation |
| alu_id | output | $clog2(NSLOT) | Index of the issuing slot |
| alu_a | output | DW | First operand to the ALU |
| alu_b | output | DW | Second operand to the ALU |
| res_valid | input | 1 | ALU result valid |
| res_id | input | $clog2(NSLOT) | Slot index carried by the result |
| res_data | input | DW | ALU result value |
| out_valid | output | NSLOT | Per-slot result valid |
| out_ready | input | NSLOT | Per-slot result consumer ready |
| out_data | output | NSLOT*DW | Per-slot result, slot i at bits [i*DW +: DW] |

## Verification
The hardest case to reach is a buffered slot that loses arbitration for several cycles. It must wait while lower-numbered slots keep arriving and issuing, and its own result must then meet a stalled consumer. The bench runs phases with different stall rates: one with ALU and consumers always ready (both bypasses), one with heavy ALU stall and busy inputs (contention among buffered slots), and one with a mostly stalled consumer (held results). A behavioural model checks the issue order, operands, routing and held outputs on every cycle.

// File: rtl/rs_alu_share.sv
module rs_alu_share #(
  parameter int NSLOT = 4,
  parameter int DW    = 16,
  localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSLOT-1:0]   in_valid,
  output logic [NSLOT-1:0]   in_ready,
  input  logic [NSLOT*DW-1:0] in_a,
  input  logic [NSLOT*DW-1:0] in_b,
  output logic               alu_valid,
  input  logic               alu_ready,
  output logic [IW-1:0]      alu_id,
  output logic [DW-1:0]      alu_a,
  output logic [DW-1:0]      alu_b,
  input  logic               res_valid,
  input  logic [IW-1:0]      res_id,
  input  logic [DW-1:0]      res_data,
  output logic [NSLOT-1:0]   out_valid,
  input  logic [NSLOT-1:0]   out_ready,
  output logic [NSLOT*DW-1:0] out_data
);

  typedef enum logic [1:0] {S_ACC, S_ISS, S_RES, S_OUT} st_t;

  st_t          st   [NSLOT];
  logic [DW-1:0] abuf [NSLOT];
  logic [DW-1:0] bbuf [NSLOT];
  logic [DW-1:0] rbuf [NSLOT];
  logic [NSLOT-1:0] req, grant, hit;
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    alu_id = '0;
    alu_a = '0;
    alu_b = '0;
    for (int i = 0; i < NSLOT; i++) begin
      req[i]      = (st[i] == S_ISS) || (st[i] == S_ACC && in_valid[i]);
      in_ready[i] = (st[i] == S_ACC);
      hit[i]      = res_valid && (res_id == IW'(i)) && (st[i] == S_RES);
      out_valid[i] = hit[i] || (st[i] == S_OUT);
      out_data[i*DW +: DW] = (st[i] == S_OUT) ? rbuf[i] : res_data;
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
        alu_id   = IW'(i);
        alu_a    = (st[i] == S_ISS) ? abuf[i] : in_a[i*DW +: DW];
        alu_b    = (st[i] == S_ISS) ? bbuf[i] : in_b[i*DW +: DW];
      end
    end
  end

  assign alu_valid = |req;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSLOT; i++) begin
      if (rst) begin
        st[i] <= S_ACC;
      end else begin
        case (st[i])
          S_ACC: if (in_valid[i]) begin
            if (grant[i] && alu_ready) st[i] <= S_RES;
            else begin
              abuf[i] <= in_a[i*DW +: DW];
              bbuf[i] <= in_b[i*DW +: DW];
              st[i]   <= S_ISS;
            end
          end
          S_ISS: if (grant[i] && alu_ready) st[i] <= S_RES;
          S_RES: if (hit[i]) begin
            if (out_ready[i]) st[i] <= S_ACC;
            else begin
              rbuf[i] <= res_data;
              st[i]   <= S_OUT;
            end
          end
          default: if (out_ready[i]) st[i] <= S_ACC;
        endcase
      end
    end
  end

  // R1
  rst_state_chk: assert property (@(posedge clk)
    rst |=> (out_valid == '0) && (in_ready == '1));

  // R5
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (alu_valid == (grant != '0)));

  // R6
  res_tag_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (st[res_id] == S_RES));

  for (genvar g = 0; g < NSLOT; g++) begin : g_chk
    // R5
    iss_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st[g] == S_ISS && !(grant[g] && alu_ready)) |=>
        (st[g] == S_ISS) && $stable(abuf[g]) && $stable(bbuf[g]));
    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid[g] && !out_ready[g]) |=>
        out_valid[g] && $stable(out_data[g*DW +: DW]));
  end

endmodule

// File: tb/test_rs_alu_share.sv
module test_rs_alu_share;
  localparam int NSLOT = 4;
  localparam int DW    = 16;
  localparam int IW    = 2;
  localparam int LAT   = 3;

  logic clk = 0, rst = 1;
  logic [NSLOT-1:0] in_valid = '0, in_ready, out_valid, out_ready = '0;
  logic [NSLOT*DW-1:0] in_a = '0, in_b = '0, out_data;
  logic alu_valid, alu_ready = 0;
  logic [IW-1:0] alu_id;
  logic [DW-1:0] alu_a, alu_b;
  logic res_valid;
  logic [IW-1:0] res_id;
  logic [DW-1:0] res_data;

  always #4 clk = ~clk;

  rs_alu_share #(.NSLOT(NSLOT), .DW(DW)) i_rs_alu_share (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .alu_valid(alu_valid), .alu_ready(alu_ready),
    .alu_id(alu_id), .alu_a(alu_a), .alu_b(alu_b), .res_valid(res_valid),
    .res_id(res_id), .res_data(res_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  // ALU model: fixed-latency adder pipeline
  logic          pv [LAT];
  logic [IW-1:0] pid [LAT];
  logic [DW-1:0] pd [LAT];
  always @(posedge clk) begin
    if (rst) for (int k = 0; k < LAT; k++) pv[k] <= 1'b0;
    else begin
      pv[0]  <= alu_valid && alu_ready;
      pid[0] <= alu_id;
      pd[0]  <= alu_a + alu_b;
      for (int k = 1; k < LAT; k++) begin
        pv[k] <= pv[k-1]; pid[k] <= pid[k-1]; pd[k] <= pd[k-1];
      end
    end
  end
  assign res_valid = pv[LAT-1];
  assign res_id    = pid[LAT-1];
  assign res_data  = pd[LAT-1];

  int errors = 0, checks = 0, n_in = 0, n_out = 0;
  bit busy [NSLOT], pend [NSLOT], got [NSLOT], hs_in [NSLOT];
  logic [DW-1:0] opa [NSLOT], opb [NSLOT], expv [NSLOT];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int pin, input int pa, input int po);
    bit want [NSLOT];
    bit any;
    int j;
    @(negedge clk);
    for (int i = 0; i < NSLOT; i++) begin
      if (!(in_valid[i] && !hs_in[i])) begin
        in_valid[i] = ($urandom_range(99) < pin);
        in_a[i*DW +: DW] = DW'($urandom);
        in_b[i*DW +: DW] = DW'($urandom);
      end
      out_ready[i] = ($urandom_range(99) < po);
    end
    alu_ready = ($urandom_range(99) < pa);
    #3;
    any = 0; j = 0;
    for (int i = 0; i < NSLOT; i++) begin
      chk(in_ready[i] == !busy[i], "R2 in_ready", in_ready[i], !busy[i]);
      hs_in[i] = in_valid[i] && in_ready[i];
      want[i]  = pend[i] || hs_in[i];
      if (want[i] && !any) begin any = 1; j = i; end
    end
    chk(alu_valid == any, "R5 alu_valid", alu_valid, any);
    if (alu_valid && any) begin
      chk(alu_id == IW'(j), "R5 R6 alu_id priority", alu_id, j);
      if (pend[j]) chk(alu_a == opa[j] && alu_b == opb[j], "R4 buffered operands", alu_a, opa[j]);
      else chk(alu_a == in_a[j*DW +: DW] && alu_b == in_b[j*DW +: DW],
               "R3 bypass operands", alu_a, in_a[j*DW +: DW]);
    end
    for (int i = 0; i < NSLOT; i++) begin
      bit rhit, ev;
      rhit = res_valid && res_id == IW'(i);
      ev = got[i] || rhit;
      if (rhit) chk(out_valid[i] == 1'b1, "R7 R6 result bypass", out_valid[i], 1);
      else chk(out_valid[i] == got[i], "R8 R6 out_valid", out_valid[i], got[i]);
      if (ev && out_valid[i])
        chk(out_data[i*DW +: DW] == expv[i], "R9 R8 out_data", out_data[i*DW +: DW], expv[i]);
      if (hs_in[i]) begin
        busy[i] = 1; pend[i] = 1; n_in++;
        opa[i] = in_a[i*DW +: DW]; opb[i] = in_b[i*DW +: DW];
        expv[i] = opa[i] + opb[i];
      end
      if (alu_valid && alu_ready && any && j == i) pend[i] = 0;
      if (ev && out_ready[i]) begin
        got[i] = 0; busy[i] = 0; n_out++;
      end else if (rhit) got[i] = 1;
    end
  endtask

  initial begin
    for (int i = 0; i < NSLOT; i++) begin
      busy[i] = 0; pend[i] = 0; got[i] = 0; hs_in[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    #3;
    chk(in_ready == '1, "R1 in_ready after reset", in_ready, 4'hF);
    chk(out_valid == '0, "R1 out_valid after reset", out_valid, 0);
    chk(alu_valid == 1'b0, "R1 alu_valid after reset", alu_valid, 0);
    for (int c = 0; c < 600; c++) step(60, 50, 50);
    for (int c = 0; c < 600; c++) step(70, 100, 100);
    for (int c = 0; c < 600; c++) step(90, 20, 30);
    for (int c = 0; c < 600; c++) step(80, 70, 10);
    for (int c = 0; c < 600; c++) step(30, 90, 90);
    for (int c = 0; c < 60; c++) step(0, 100, 100);
    chk(n_in == n_out, "R9 no loss or duplication", n_out, n_in);
    chk(in_ready == '1, "R9 R2 all slots drained", in_ready, 4'hF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule